// File: doc/BRIEF.md
# Privilege-Masked Authority Register Bank

This block holds the 64-bit protection-control state that a core's memory-protection logic consumes. There are four registers: an authority mask, a user override mask, a supervisor override mask, and an optional instruction authority mask. A single request port reaches them. Each request carries a register select, a write enable, write data and a two-bit privilege level.

At hypervisor level a write stores the data as given. At lower levels the write is merged bit by bit: `new = (old & ~M) | (wdata & M)`, where the mask M is itself one of the bank's registers, chosen by the privilege of the request. User-level writes are masked by the user override register. Supervisor-level writes are masked by the supervisor override register.

A request that is not allowed changes nothing, reads back zero and raises the error output. A configuration input forces the supervisor override register to all ones. In that mode supervisor code may write every bit.

The request port uses valid/ready. The bank never applies back-pressure: `req_ready` is always high, and every request with `req_valid` high is accepted in that cycle. The read result and the error flag are combinational answers to the request presented in that cycle. Writes land on the next rising clock edge.

Top module: `auth_mask_bank`

## Requirements
- R1: After reset, every register reads as zero. This holds with `cfg_full_perm` low.
- R2: Select codes 0 and 1 both reach the authority mask: code 0 is the alias open to user level, code 1 the privileged alias. Privilege codes are 0 user, 1 supervisor, 2 hypervisor and 3 reserved. A user-level write through code 0 changes only the bits set in the user override register.
- R3: A supervisor-level write to the authority mask, through either code 0 or code 1, changes only the bits set in the effective supervisor override value.
- R4: A hypervisor-level write to any implemented register stores the full write data.
- R5: A supervisor-level write to the user override register (select code 2) changes only the bits set in the effective supervisor override value.
- R6: A supervisor-level write to the instruction authority mask (select code 4) changes only the bits set in the effective supervisor override value.
- R7: The supervisor override register (select code 3) can be read or written only at hypervisor level.
- R8: The following requests are denied:
  - at user level, select codes 1, 2, 3 and 4;
  - any request at reserved privilege code 3;
  - select codes 5 to 7 at every level.
- R9: For a denied request, `err` is high in the same cycle and `rd_data` is zero. No register changes at the following edge.
- R10: While `cfg_full_perm` is high:
  - the supervisor override register reads as all ones;
  - writes to it have no effect;
  - it is loaded with all ones at every edge, so it stays all ones after the mode ends until a hypervisor write replaces it.
- R11: When the `HAS_IMASK` parameter is 0, select code 4 is denied at every privilege level.
- R12: An allowed request returns the selected register's current value on `rd_data`. For a write, this is the value before the write. The written value is visible from the next cycle.
- R13: `req_ready` is always high. With `req_valid` low, `err` is low, `rd_data` is zero and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_full_perm | input | 1 | Forces the supervisor override register to all ones |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high; the bank accepts every request |
| req_sel | input | 3 | Register select code |
| req_priv | input | 2 | Privilege level of the request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | W | Write data |
| rd_data | output | W | Current value of the selected register, zero if denied or idle |
| err | output | 1 | High for a denied request |

## Verification
The checker enforces these properties on every cycle:
- a denied or idle cycle leaves the masks untouched, and a denial reads zero;
- after a user write, no bit outside the previous user override changed, and after a supervisor write, no bit outside the previous supervisor override changed;
- the supervisor override moves only on a hypervisor write or in full-permission mode;
- select codes 5 to 7 always raise an error.

The bench's scenarios cover what those properties cannot pin down. They show that the permitted bits actually take the new data, that both authority mask aliases behave alike, and that the value before a write reads back in the write cycle. They also show that full-permission mode leaves ones behind when it ends, and that a build without the instruction mask denies its select.

// File: rtl/amb_pkg.sv
package amb_pkg;
  localparam logic [2:0] SEL_AMR_U = 3'd0;
  localparam logic [2:0] SEL_AMR_P = 3'd1;
  localparam logic [2:0] SEL_UOVR  = 3'd2;
  localparam logic [2:0] SEL_SOVR  = 3'd3;
  localparam logic [2:0] SEL_IMASK = 3'd4;

  localparam logic [1:0] PL_USER = 2'd0;
  localparam logic [1:0] PL_SUP  = 2'd1;
  localparam logic [1:0] PL_HYP  = 2'd2;

  typedef enum logic [1:0] {
    MS_UOVR = 2'd0,
    MS_SOVR = 2'd1,
    MS_FULL = 2'd2
  } mask_src_e;
endpackage

// File: rtl/amb_access.sv
module amb_access
  import amb_pkg::*;
#(
  parameter bit HAS_IMASK = 1'b1
) (
  input  logic       valid,
  input  logic [2:0] sel,
  input  logic [1:0] priv,
  output logic       grant,
  output logic       deny,
  output mask_src_e  msrc
);
  logic ok;
  logic priv_hi;

  assign priv_hi = (priv == PL_SUP) || (priv == PL_HYP);

  always_comb begin
    ok = 1'b0;
    case (sel)
      SEL_AMR_U: ok = (priv == PL_USER) || priv_hi;
      SEL_AMR_P: ok = priv_hi;
      SEL_UOVR:  ok = priv_hi;
      SEL_SOVR:  ok = (priv == PL_HYP);
      SEL_IMASK: ok = HAS_IMASK && priv_hi;
      default:   ok = 1'b0;
    endcase
  end

  always_comb begin
    if (sel == SEL_SOVR || priv == PL_HYP) msrc = MS_FULL;
    else if (priv == PL_SUP)               msrc = MS_SOVR;
    else                                   msrc = MS_UOVR;
  end

  assign grant = valid && ok;
  assign deny  = valid && !ok;
endmodule

// File: rtl/amb_merge.sv
module amb_merge #(
  parameter int W = 64
) (
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] new_val,
  input  logic [W-1:0] mask,
  output logic [W-1:0] merged
);
  assign merged = (old_val & ~mask) | (new_val & mask);
endmodule

// File: rtl/amb_reg.sv
module amb_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/auth_mask_bank.sv
module auth_mask_bank
  import amb_pkg::*;
#(
  parameter int W         = 64,
  parameter bit HAS_IMASK = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_full_perm,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [2:0]   req_sel,
  input  logic [1:0]   req_priv,
  input  logic         req_we,
  input  logic [W-1:0] req_wdata,
  output logic [W-1:0] rd_data,
  output logic         err
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic         grant, deny, wr;
  mask_src_e    msrc;
  logic [W-1:0] amr_q, uovr_q, sovr_q, imask_q;
  logic [W-1:0] sovr_eff, mask, old_val, merged;

  amb_access #(.HAS_IMASK(HAS_IMASK)) u_access (
    .valid (req_valid),
    .sel   (req_sel),
    .priv  (req_priv),
    .grant (grant),
    .deny  (deny),
    .msrc  (msrc)
  );

  assign sovr_eff = cfg_full_perm ? ALL_ONES : sovr_q;

  always_comb begin
    case (msrc)
      MS_UOVR: mask = uovr_q;
      MS_SOVR: mask = sovr_eff;
      default: mask = ALL_ONES;
    endcase
  end

  always_comb begin
    case (req_sel)
      SEL_AMR_U, SEL_AMR_P: old_val = amr_q;
      SEL_UOVR:             old_val = uovr_q;
      SEL_SOVR:             old_val = sovr_eff;
      SEL_IMASK:            old_val = imask_q;
      default:              old_val = '0;
    endcase
  end

  amb_merge #(.W(W)) u_merge (
    .old_val (old_val),
    .new_val (req_wdata),
    .mask    (mask),
    .merged  (merged)
  );

  assign wr = grant && req_we;

  amb_reg #(.W(W)) u_amr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (wr && (req_sel == SEL_AMR_U || req_sel == SEL_AMR_P)),
    .d     (merged),
    .q     (amr_q)
  );

  amb_reg #(.W(W)) u_uovr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (wr && req_sel == SEL_UOVR),
    .d     (merged),
    .q     (uovr_q)
  );

  generate
    if (HAS_IMASK) begin : g_imask
      amb_reg #(.W(W)) u_imask (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (wr && req_sel == SEL_IMASK),
        .d     (merged),
        .q     (imask_q)
      );
    end else begin : g_no_imask
      assign imask_q = '0;
    end
  endgenerate

  // Supervisor override: pinned to ones while full-permission mode is on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sovr_q <= '0;
    else if (cfg_full_perm)              sovr_q <= ALL_ONES;
    else if (wr && req_sel == SEL_SOVR)  sovr_q <= req_wdata;
  end

  assign req_ready = 1'b1;
  assign rd_data   = grant ? old_val : '0;
  assign err       = deny;
endmodule

// File: rtl/amb_checker.sv
module amb_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_full_perm,
  input logic         req_valid,
  input logic         req_we,
  input logic [2:0]   req_sel,
  input logic [1:0]   req_priv,
  input logic [W-1:0] rd_data,
  input logic         err,
  input logic [W-1:0] amr_q,
  input logic [W-1:0] uovr_q,
  input logic [W-1:0] sovr_q,
  input logic [W-1:0] imask_q
);
  logic ok_wr;
  assign ok_wr = req_valid && !err && req_we;

  AST_DENY_RDZERO: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rd_data == '0); // R9

  AST_DENY_NOCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> ($stable(amr_q) && $stable(uovr_q) && $stable(imask_q))); // R9

  AST_IDLE_NOCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(amr_q) && $stable(uovr_q) && $stable(imask_q))); // R13

  AST_USER_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_wr && req_priv == 2'd0) |=>
      (((amr_q ^ $past(amr_q)) & ~$past(uovr_q)) == '0)); // R2

  AST_SUP_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_wr && req_priv == 2'd1 && !cfg_full_perm) |=>
      ((((amr_q ^ $past(amr_q)) | (uovr_q ^ $past(uovr_q)) |
         (imask_q ^ $past(imask_q))) & ~$past(sovr_q)) == '0)); // R3

  AST_SOVR_HYP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_full_perm && !(ok_wr && req_priv == 2'd2 && req_sel == 3'd3))
      |=> $stable(sovr_q)); // R7

  AST_FULL_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_full_perm |=> sovr_q == {W{1'b1}}); // R10

  AST_UNIMPL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel >= 3'd5) |-> err); // R8
endmodule

bind auth_mask_bank amb_checker #(.W(W)) u_amb_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_full_perm (cfg_full_perm),
  .req_valid     (req_valid),
  .req_we        (req_we),
  .req_sel       (req_sel),
  .req_priv      (req_priv),
  .rd_data       (rd_data),
  .err           (err),
  .amr_q         (amr_q),
  .uovr_q        (uovr_q),
  .sovr_q        (sovr_q),
  .imask_q       (imask_q)
);

// File: tb/tb_auth_mask_bank.sv
module tb_auth_mask_bank;
  localparam int W = 64;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, cfg, valid, we;
  logic [2:0]   sel;
  logic [1:0]   pl;
  logic [W-1:0] wdata, rd, rd_ni;
  logic         err, err_ni, rdy, rdy_ni;

  auth_mask_bank #(.W(W), .HAS_IMASK(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_full_perm(cfg), .req_valid(valid),
    .req_ready(rdy), .req_sel(sel), .req_priv(pl), .req_we(we),
    .req_wdata(wdata), .rd_data(rd), .err(err));

  auth_mask_bank #(.W(W), .HAS_IMASK(1'b0)) dut_ni (
    .clk(clk), .rst_n(rst_n), .cfg_full_perm(cfg), .req_valid(valid),
    .req_ready(rdy_ni), .req_sel(sel), .req_priv(pl), .req_we(we),
    .req_wdata(wdata), .rd_data(rd_ni), .err(err_ni));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [W-1:0] m_amr, m_uovr, m_sovr, m_imask;

  function automatic bit allowed(int s, int p, bit has);
    if (p == 3) return 1'b0;
    case (s)
      0: return 1'b1;
      1, 2: return p >= 1;
      3: return p == 2;
      4: return has && p >= 1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [W-1:0] cur(int s, bit has);
    case (s)
      0, 1: return m_amr;
      2: return m_uovr;
      3: return cfg ? ONES : m_sovr;
      4: return has ? m_imask : '0;
      default: return '0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(int s, int p, bit w, logic [W-1:0] d, string tov);
    bit ok, okn;
    string tag;
    logic [W-1:0] m, old, e_rd;
    @(negedge clk);
    valid = 1'b1; sel = 3'(s); pl = 2'(p); we = w; wdata = d;
    #1;
    ok  = allowed(s, p, 1'b1);
    okn = allowed(s, p, 1'b0);
    if (!ok) tag = (s == 3 && p != 3) ? "R7" : "R8";
    else if (!w) tag = "R12";
    else if (p == 2) tag = "R4";
    else if (s == 2) tag = "R5";
    else if (s == 4) tag = "R6";
    else tag = (p == 0) ? "R2" : "R3";
    if (tov != "") tag = tov;
    old  = cur(s, 1'b1);
    e_rd = ok ? old : '0;
    chk(err == !ok, "R9 err", W'(err), W'(!ok));
    chk(rd == e_rd, tag, rd, e_rd);
    chk(err_ni == !okn, (s == 4) ? "R11 err" : "R9 err", W'(err_ni), W'(!okn));
    chk(rd_ni == (okn ? cur(s, 1'b0) : '0), (s == 4) ? "R11" : tag,
        rd_ni, okn ? cur(s, 1'b0) : '0);
    if (p == 2 || s == 3) m = ONES;
    else if (p == 1)      m = cfg ? ONES : m_sovr;
    else                  m = m_uovr;
    @(posedge clk);
    if (ok && w) begin
      case (s)
        0, 1: m_amr   = (old & ~m) | (d & m);
        2:    m_uovr  = (old & ~m) | (d & m);
        3:    if (!cfg) m_sovr = d;
        4:    m_imask = (old & ~m) | (d & m);
        default: ;
      endcase
    end
    if (cfg) m_sovr = ONES;
  endtask

  task automatic idle(bit c);
    @(negedge clk);
    valid = 1'b0; cfg = c;
    #1;
    chk(err == 1'b0, "R13 err idle", W'(err), '0);
    chk(rd == '0, "R13 rd idle", rd, '0);
    chk(rdy == 1'b1 && rdy_ni == 1'b1, "R13 ready", W'(rdy), W'(1));
    @(posedge clk);
    if (cfg) m_sovr = ONES;
  endtask

  initial begin
    rst_n = 1'b0; cfg = 1'b0; valid = 1'b0; we = 1'b0;
    sel = '0; pl = '0; wdata = '0;
    m_amr = '0; m_uovr = '0; m_sovr = '0; m_imask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state at hypervisor level
    for (int s = 0; s < 5; s++) req(s, 2, 1'b0, '0, "R1");

    // R12: value before the write in the write cycle, new value after
    req(0, 2, 1'b1, 64'h0123_4567_89AB_CDEF, "R12");
    req(1, 2, 1'b0, '0, "R12");

    // R2/R3: partial masks, then masked user and supervisor writes
    req(2, 2, 1'b1, 64'h00FF_00FF_00FF_00FF, "R4");
    req(3, 2, 1'b1, 64'hF0F0_F0F0_0F0F_0F0F, "R4");
    req(0, 0, 1'b1, ONES, "R2");
    req(0, 0, 1'b0, '0, "R2");
    req(1, 1, 1'b1, '0, "R3");
    req(0, 1, 1'b0, '0, "R3");

    // R10: full-permission mode and what it leaves behind
    idle(1'b1);
    req(3, 2, 1'b1, '0, "R10");
    req(3, 2, 1'b0, '0, "R10");
    req(4, 1, 1'b1, 64'hDEAD_BEEF_0000_1234, "R10");
    idle(1'b0);
    req(3, 2, 1'b0, '0, "R10");

    // Sweep: every select, privilege and direction across several rounds
    for (int r = 0; r < 8; r++) begin
      for (int p = 0; p < 4; p++) begin
        idle(r == 3 || r == 4);
        for (int s = 0; s < 8; s++) begin
          for (int w = 0; w < 2; w++) begin
            req(s, p, w[0], {$urandom(), $urandom()},
                (cfg && (s == 3 || p == 1)) ? "R10" : "");
          end
        end
      end
    end
    idle(1'b0);
    for (int s = 0; s < 5; s++) req(s, 2, 1'b0, '0, "R13");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule